// File: doc/BRIEF.md
# Gated Source-Selectable Clock-Enable Divider

This block turns a stream of source ticks into a slower stream of single-cycle enable strobes. Everything runs on one system clock. Two candidate tick inputs, a slow one and a fast one, arrive as one-cycle qualifiers. A select bit picks which of them is counted. A gate bit starts or stops the whole stream. A divider field sets how many selected ticks make up one output period. The block drives a downstream clock-enable, never a derived clock.

The divider field is decoded before counting. A static parameter picks one of four decodings: pass-through, field plus one, twice the field plus one, or a power of two. The decoded ratio is held in a register and is replaced only at a period boundary. Every output period is therefore complete. When the boundary adopts a different ratio, a one-cycle acknowledge goes out alongside the strobe.

Top module: `clkdiv_gated`

## Requirements
- R1: With `DIV_KIND` = DIV_PLUS1 (encoding 1), one strobe is produced per `div_val`+1 selected ticks.
- R2: With `DIV_KIND` = DIV_TWICE (encoding 2), one strobe is produced per 2×(`div_val`+1) selected ticks.
- R3: With `DIV_KIND` = DIV_POW2 (encoding 3), one strobe is produced per 2<<s selected ticks, where s = `div_val`. A field of 0 gives a ratio of 2. s is clamped to the smaller of `POW2_MAX_SHIFT` and 2^`FIELD_W`−1.
- R4: With `DIV_KIND` = DIV_BYPASS (encoding 0), every selected tick yields a strobe, and `div_val` has no effect.
- R5: While `gate_en` is 0, `clk_en_o` and `rate_ack_o` stay 0 and the tick count is cleared. The first strobe after `gate_en` returns to 1 comes after exactly one full ratio of ticks, counted from the current field.
- R6: `src_sel` = 0 counts `slow_tick` and `src_sel` = 1 counts `fast_tick`. In the cycle where `src_sel` differs from its value at the previous edge, the count restarts from zero and that cycle's tick is not counted.
- R7: A strobe is high for one cycle. It appears in the cycle after the edge at which the terminal selected tick was sampled.
- R8: A changed `div_val` takes effect only at the next terminal count. `rate_ack_o` pulses together with the strobe whose boundary adopts a ratio different from the one just completed.
- R9: After reset, both outputs are 0, the held ratio is 1 and the select state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_en | input | 1 | 1 lets strobes run; 0 stops them and clears the count |
| src_sel | input | 1 | 0 selects slow_tick, 1 selects fast_tick |
| slow_tick | input | 1 | Slow source qualifier, one cycle per source tick |
| fast_tick | input | 1 | Fast source qualifier, one cycle per source tick |
| div_val | input | FIELD_W | Divider field, decoded according to DIV_KIND |
| clk_en_o | output | 1 | One-cycle enable strobe at the divided rate |
| rate_ack_o | output | 1 | Pulses with the strobe that adopts a changed ratio |

## Verification
The bench builds four copies side by side, all driven by the same inputs:
- twice-plus-one with an 8-bit field;
- plus-one with a 4-bit field;
- power-of-two with a 3-bit field and a shift limit of 4;
- pass-through with a 16-bit field.

The narrow power-of-two copy lets field values above the limit reach the clamp. Sharing the inputs makes each ratio change, gate drop and source switch land mid-period in one decoding while it hits a boundary in another. The wide pass-through copy shows that the field is ignored in that mode, even at full width.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        DIV_BYPASS = 2'd0,
        DIV_PLUS1  = 2'd1,
        DIV_TWICE  = 2'd2,
        DIV_POW2   = 2'd3
    } div_kind_e;

    // Largest usable shift for power-of-two decoding
    function automatic int eff_shift(int field_w, int max_shift);
        int field_max;
        field_max = (1 << field_w) - 1;
        return (max_shift < field_max) ? max_shift : field_max;
    endfunction

    // Width of the stored terminal value (ratio minus one)
    function automatic int term_width(div_kind_e kind, int field_w, int max_shift);
        case (kind)
            DIV_BYPASS: return 1;
            DIV_PLUS1:  return field_w;
            DIV_TWICE:  return field_w + 1;
            default:    return eff_shift(field_w, max_shift) + 1;
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
    parameter clkdiv_pkg::div_kind_e DIV_KIND = clkdiv_pkg::DIV_TWICE,
    parameter int FIELD_W   = 8,
    parameter int MAX_SHIFT = 15,
    parameter int TERM_W    = 9
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [TERM_W-1:0]  term_o
);
    generate
        if (DIV_KIND == clkdiv_pkg::DIV_BYPASS) begin : g_bypass
            logic unused_field;
            assign unused_field = ^field_i;
            assign term_o = '0;
        end else if (DIV_KIND == clkdiv_pkg::DIV_PLUS1) begin : g_plus1
            assign term_o = TERM_W'(field_i);
        end else if (DIV_KIND == clkdiv_pkg::DIV_TWICE) begin : g_twice
            assign term_o = TERM_W'({field_i, 1'b1});
        end else begin : g_pow2
            localparam int SH_W = $clog2(MAX_SHIFT + 2);
            logic [SH_W-1:0]  shift;
            logic [TERM_W:0]  weight;
            always_comb begin
                if (field_i > FIELD_W'(MAX_SHIFT)) begin
                    shift = SH_W'(MAX_SHIFT);
                end else begin
                    shift = SH_W'(field_i);
                end
                weight = (TERM_W + 1)'(1) << (shift + 1'b1);
                term_o = TERM_W'(weight - 1'b1);
            end
        end
    endgenerate
endmodule

// File: rtl/clkdiv_srcsel.sv
module clkdiv_srcsel (
    input  logic clk,
    input  logic rst_ni,
    input  logic src_sel_i,
    input  logic slow_i,
    input  logic fast_i,
    output logic tick_o,
    output logic restart_o
);
    typedef struct packed {
        logic sel;
    } sel_state_t;

    sel_state_t sel_d, sel_q;

    always_comb begin
        sel_d     = sel_q;
        sel_d.sel = src_sel_i;
        tick_o    = src_sel_i ? fast_i : slow_i;
        restart_o = (src_sel_i != sel_q.sel);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
    parameter int TERM_W = 9
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              gate_i,
    input  logic              tick_i,
    input  logic              restart_i,
    input  logic [TERM_W-1:0] dec_term_i,
    output logic              en_o,
    output logic              ack_o,
    output logic [TERM_W-1:0] term_o
);
    typedef struct packed {
        logic [TERM_W-1:0] cnt;
        logic [TERM_W-1:0] term;
        logic              en;
        logic              ack;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.en  = 1'b0;
        st_d.ack = 1'b0;
        if (!gate_i) begin
            st_d.cnt  = '0;
            st_d.term = dec_term_i;
        end else if (restart_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == st_q.term) begin
                st_d.en   = 1'b1;
                st_d.cnt  = '0;
                st_d.ack  = (dec_term_i != st_q.term);
                st_d.term = dec_term_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign ack_o  = st_q.ack;
    assign term_o = st_q.term;
endmodule

// File: rtl/clkdiv_gated.sv
module clkdiv_gated #(
    parameter clkdiv_pkg::div_kind_e DIV_KIND = clkdiv_pkg::DIV_TWICE,
    parameter int FIELD_W        = 8,
    parameter int POW2_MAX_SHIFT = 15
) (
    input  logic               clk,
    input  logic               rst_ni,
    input  logic               gate_en,
    input  logic               src_sel,
    input  logic               slow_tick,
    input  logic               fast_tick,
    input  logic [FIELD_W-1:0] div_val,
    output logic               clk_en_o,
    output logic               rate_ack_o
);
    localparam int SHIFT_LIM = clkdiv_pkg::eff_shift(FIELD_W, POW2_MAX_SHIFT);
    localparam int TERM_W    = clkdiv_pkg::term_width(DIV_KIND, FIELD_W, POW2_MAX_SHIFT);

    logic              sel_tick;
    logic              sel_restart;
    logic [TERM_W-1:0] dec_term;
    logic [TERM_W-1:0] active_term;

    clkdiv_srcsel u_src (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .src_sel_i (src_sel),
        .slow_i    (slow_tick),
        .fast_i    (fast_tick),
        .tick_o    (sel_tick),
        .restart_o (sel_restart)
    );

    clkdiv_decode #(
        .DIV_KIND  (DIV_KIND),
        .FIELD_W   (FIELD_W),
        .MAX_SHIFT (SHIFT_LIM),
        .TERM_W    (TERM_W)
    ) u_dec (
        .field_i (div_val),
        .term_o  (dec_term)
    );

    clkdiv_count #(
        .TERM_W (TERM_W)
    ) u_cnt (
        .clk        (clk),
        .rst_ni     (rst_ni),
        .gate_i     (gate_en),
        .tick_i     (sel_tick),
        .restart_i  (sel_restart),
        .dec_term_i (dec_term),
        .en_o       (clk_en_o),
        .ack_o      (rate_ack_o),
        .term_o     (active_term)
    );
endmodule

// File: rtl/clkdiv_gated_chk.sv
module clkdiv_gated_chk #(
    parameter int TERM_W = 9
) (
    input logic              clk,
    input logic              rst_ni,
    input logic              gate_en,
    input logic              src_sel,
    input logic              slow_tick,
    input logic              fast_tick,
    input logic              clk_en_o,
    input logic              rate_ack_o,
    input logic [TERM_W-1:0] held_term
);
    // R5: a low gate at an edge silences the next cycle
    a_r5_gate_silences: assert property (@(posedge clk) disable iff (!rst_ni)
        !gate_en |=> (!clk_en_o && !rate_ack_o));

    // R6: a source switch never produces a strobe in the following cycle
    a_r6_switch_restart: assert property (@(posedge clk) disable iff (!rst_ni)
        (src_sel != $past(src_sel)) |=> !clk_en_o);

    // R7: a strobe follows a sampled tick of the selected source
    a_r7_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_ni)
        clk_en_o |-> $past(src_sel ? fast_tick : slow_tick));

    // R8: acknowledge only travels with a strobe
    a_r8_ack_with_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
        rate_ack_o |-> clk_en_o);

    // R8: held ratio changes only at a boundary or while gated
    a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_ni)
        !$stable(held_term) |-> (clk_en_o || !$past(gate_en)));
endmodule

bind clkdiv_gated clkdiv_gated_chk #(.TERM_W(TERM_W)) chk_i (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .gate_en    (gate_en),
    .src_sel    (src_sel),
    .slow_tick  (slow_tick),
    .fast_tick  (fast_tick),
    .clk_en_o   (clk_en_o),
    .rate_ack_o (rate_ack_o),
    .held_term  (active_term)
);

// File: tb/clkdiv_gated_tb_top.sv
`timescale 1ns/1ps
module clkdiv_gated_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_ni = 1'b0;
    logic        gate_en = 1'b0;
    logic        src_sel = 1'b0;
    logic        slow_tick = 1'b0;
    logic        fast_tick = 1'b0;
    logic [15:0] div_val = '0;
    logic [3:0]  en_w;
    logic [3:0]  ack_w;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    int    pat = 0;
    bit    done = 1'b0;
    string phase = "R9";

    // instance 0: twice (R2), 1: plus1 (R1), 2: pow2 (R3), 3: bypass (R4)
    int    kind_of [4] = '{2, 1, 3, 0};
    int    width_of[4] = '{8, 4, 3, 16};
    string req_of  [4] = '{"R2", "R1", "R3", "R4"};
    localparam int POW2_LIM = 4;

    clkdiv_gated #(.DIV_KIND(clkdiv_pkg::DIV_TWICE), .FIELD_W(8)) dut_i (
        .clk(clk), .rst_ni(rst_ni), .gate_en(gate_en), .src_sel(src_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .div_val(div_val[7:0]),
        .clk_en_o(en_w[0]), .rate_ack_o(ack_w[0]));

    clkdiv_gated #(.DIV_KIND(clkdiv_pkg::DIV_PLUS1), .FIELD_W(4)) dut_plus1 (
        .clk(clk), .rst_ni(rst_ni), .gate_en(gate_en), .src_sel(src_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .div_val(div_val[3:0]),
        .clk_en_o(en_w[1]), .rate_ack_o(ack_w[1]));

    clkdiv_gated #(.DIV_KIND(clkdiv_pkg::DIV_POW2), .FIELD_W(3),
                   .POW2_MAX_SHIFT(POW2_LIM)) dut_pow2 (
        .clk(clk), .rst_ni(rst_ni), .gate_en(gate_en), .src_sel(src_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .div_val(div_val[2:0]),
        .clk_en_o(en_w[2]), .rate_ack_o(ack_w[2]));

    clkdiv_gated #(.DIV_KIND(clkdiv_pkg::DIV_BYPASS), .FIELD_W(16)) dut_pass (
        .clk(clk), .rst_ni(rst_ni), .gate_en(gate_en), .src_sel(src_sel),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .div_val(div_val),
        .clk_en_o(en_w[3]), .rate_ack_o(ack_w[3]));

    // Expected terminal count (ratio minus one) from the requirements
    function automatic int ref_term(int kind, int w, int v);
        int f;
        int s;
        f = v & ((1 << w) - 1);
        case (kind)
            0: return 0;
            1: return f;
            2: return 2 * f + 1;
            default: begin
                s = (f > POW2_LIM) ? POW2_LIM : f;
                return (2 << s) - 1;
            end
        endcase
    endfunction

    int m_cnt [4];
    int m_term[4];
    bit m_sel [4];
    bit m_en  [4];
    bit m_ack [4];

    // Behavioural reference, advanced on every clock edge
    always @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            int  want;
            bit  tk;
            if (!rst_ni) begin
                m_cnt[k] = 0; m_term[k] = 0; m_sel[k] = 0; m_en[k] = 0; m_ack[k] = 0;
            end else begin
                want = ref_term(kind_of[k], width_of[k], int'(div_val));
                tk   = src_sel ? fast_tick : slow_tick;
                m_en[k] = 0;
                m_ack[k] = 0;
                if (!gate_en) begin
                    m_cnt[k] = 0;
                    m_term[k] = want;
                end else if (src_sel != m_sel[k]) begin
                    m_cnt[k] = 0;
                end else if (tk) begin
                    if (m_cnt[k] == m_term[k]) begin
                        m_en[k] = 1;
                        m_ack[k] = (want != m_term[k]);
                        m_cnt[k] = 0;
                        m_term[k] = want;
                    end else begin
                        m_cnt[k] = m_cnt[k] + 1;
                    end
                end
                m_sel[k] = src_sel;
            end
        end
    end

    task automatic compare_all();
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (en_w[k] !== m_en[k]) begin
                failures++;
                $display("FAIL %s/%s R7 strobe inst %0d cycle %0d: actual=%b expected=%b",
                         phase, req_of[k], k, cyc, en_w[k], m_en[k]);
            end
            checks++;
            if (ack_w[k] !== m_ack[k]) begin
                failures++;
                $display("FAIL %s/%s R8 ack inst %0d cycle %0d: actual=%b expected=%b",
                         phase, req_of[k], k, cyc, ack_w[k], m_ack[k]);
            end
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare_all();
            if (pat == 0) fast_tick = 1'b1;
            else          fast_tick = ((cyc % 4) != 3);
            slow_tick = ((cyc % 7) == 0);
        end
    endtask

    initial begin
        // R9: outputs idle in and out of reset
        phase = "R9";
        step(4);
        rst_ni = 1'b1;
        step(3);

        // R1 R2 R3 R4 R7: steady division on the fast source
        phase = "R1 R2 R3 R4 R7";
        gate_en = 1'b1;
        src_sel = 1'b1;
        div_val = 16'd3;
        step(80);
        div_val = 16'd0;
        step(40);
        div_val = 16'd9;
        step(200);

        // R3: field above the shift limit is clamped
        phase = "R3 clamp";
        div_val = 16'd7;
        step(160);
        div_val = 16'hFFF5;
        step(150);

        // R8: field changes mid-period wait for the boundary
        phase = "R8";
        div_val = 16'd2;
        step(30);
        for (int j = 0; j < 12; j++) begin
            div_val = 16'((j % 4) + 1);
            step(7);
        end
        step(40);

        // R5: gate removal and re-enable
        phase = "R5";
        gate_en = 1'b0;
        step(20);
        gate_en = 1'b1;
        step(60);
        gate_en = 1'b0;
        step(1);
        gate_en = 1'b1;
        step(40);

        // R6: source selection and restart on switch
        phase = "R6";
        src_sel = 1'b0;
        step(120);
        src_sel = 1'b1;
        step(3);
        src_sel = 1'b0;
        step(1);
        src_sel = 1'b1;
        step(50);
        pat = 1;
        step(120);
        src_sel = 1'b0;
        step(60);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule